// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Optional Ninth Bit

This block sends bytes on a single serial line in asynchronous frames. Software writes an 8-bit control byte that turns the transmitter on, picks 8-bit or 9-bit frames, supplies the ninth data bit and picks one of two speeds. A separate write strobe fills a one-byte holding register. A byte in that register moves into the shift register once the shift register is empty. The frame on `txd` is then a low start bit, the data bits least significant first, the optional ninth bit, and a high stop bit. Between frames the line rests high.

The ninth bit can be used as an address marker or a parity bit that software computes. It is sampled together with the frame length and speed at the moment the byte moves into the shift register. Each bit lasts a number of baud ticks: 16 at high speed and 64 at low speed. One baud tick occurs every divisor+1 clocks, where the divisor is a writable register that resets to 0. A read-only status bit in the control byte shows whether the shift register is empty.

The sequencer has five named states. IDLE goes to START on a load, which needs the transmitter enabled, a byte held, and IDLE. START goes to DATA at the end of the bit. DATA goes to NINTH after the last data bit in 9-bit frames, or to STOP in 8-bit frames. NINTH goes to STOP. STOP goes to IDLE. Any busy state falls back to IDLE when the enable bit is clear.

Top module: `ser_tx9`

## Requirements
- R1: After reset `txd` is 1 and `ctl_rdata` reads 0x10 (only the empty bit, bit 4, set); the line is 1 whenever the empty bit is 1.
- R2: A frame is one 0 start bit, then the eight data bits least significant first, then one 1 stop bit, when the nine-bit mode (control bit 1) is 0.
- R3: With control bit 1 set, the frame carries a ninth bit, equal to control bit 2, between data bit 7 and the stop bit.
- R4: Each bit lasts (divisor+1)*16 clocks when the speed bit (control bit 3) is 1 and (divisor+1)*64 clocks when it is 0.
- R5: The empty bit (bit 4) falls the clock after a load and rises exactly (frame bits)*(bit period) clocks later, where frame bits is 10 or 11; a load only takes a held byte.
- R6: While the enable bit (control bit 0) is 0, a written byte stays in the holding register and nothing is sent; setting the enable bit starts its frame on the next clock.
- R7: Clearing the enable bit during a frame returns the line to 1 and the empty bit to 1 one clock after the write takes effect.
- R8: The ninth bit, the frame length and the speed are sampled at load; control writes during a frame do not change that frame.
- R9: Bit 5 (mode select) and bit 7 always read 0; bit 6 (clock source) reads back as written and has no effect on frames.
- R10: A byte written while a frame is in progress starts its frame one clock after the current stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rdata | output | 8 | Control fields and empty status |
| data_wr | input | 1 | Write strobe for the holding register |
| data_wdata | input | 8 | Byte to send |
| div_wr | input | 1 | Write strobe for the baud divisor |
| div_wdata | input | DIV_W | Baud divisor value |
| txd | output | 1 | Serial line, idles at 1 |

## Verification
A byte written at clock edge E loads at E+1. From there the start bit and each later bit occupy one full bit period T, so bit k is sampled half a period into its slot, counted in clocks from the first falling-edge sample after E+1. The empty bit must read 0 for exactly (frame bits)*T samples and 1 on the sample after. A disable takes effect one clock after its write, and the bench checks the line on that very sample. A byte queued behind a frame is expected to start one clock after the idle sample that ends the previous frame, and the bench counts it from there.

// File: rtl/ser_tx9_pkg.sv
package ser_tx9_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_NINTH = 3'd3,
        S_STOP  = 3'd4
    } tx_state_e;

    localparam int F_EN    = 0;
    localparam int F_NINE  = 1;
    localparam int F_D9    = 2;
    localparam int F_FAST  = 3;
    localparam int F_EMPTY = 4;
    localparam int F_SYNC  = 5;
    localparam int F_CLK   = 6;

endpackage

// File: rtl/ser_tx9_baud.sv
module ser_tx9_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q >= div);
    assign tick = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ser_tx9_fsm.sv
module ser_tx9_fsm
    import ser_tx9_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FAST_TICKS = 16,
    parameter int SLOW_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              nine,
    input  logic              d9,
    input  logic              fast,
    output logic              load,
    output logic              txd,
    output logic              shift_empty,
    output logic              run
);

    localparam int TCNT_W = $clog2(SLOW_TICKS);
    localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [TCNT_W-1:0] LAST_FAST = TCNT_W'(FAST_TICKS - 1);
    localparam logic [TCNT_W-1:0] LAST_SLOW = TCNT_W'(SLOW_TICKS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [TCNT_W-1:0] tcnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              nine_s, d9_s, fast_s;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == (fast_s ? LAST_FAST : LAST_SLOW));
    assign load    = (state_q == S_IDLE) && en && hold_full;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (load) state_d = S_START;
            S_START: if (bit_end) state_d = S_DATA;
            S_DATA:  if (bit_end && bit_q == LAST_BIT) state_d = nine_s ? S_NINTH : S_STOP;
            S_NINTH: if (bit_end) state_d = S_STOP;
            S_STOP:  if (bit_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (state_q != S_IDLE && !en) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // shift register, tick and bit counters, sampled frame options
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            nine_s <= 1'b0;
            d9_s   <= 1'b0;
            fast_s <= 1'b0;
        end else if (load) begin
            tcnt_q <= '0;
            bit_q  <= '0;
            sh_q   <= hold_data;
            nine_s <= nine;
            d9_s   <= d9;
            fast_s <= fast;
        end else if (state_q != S_IDLE && tick) begin
            tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
            if (bit_end && state_q == S_DATA) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_IDLE:  txd = 1'b1;
            S_START: txd = 1'b0;
            S_DATA:  txd = sh_q[0];
            S_NINTH: txd = d9_s;
            S_STOP:  txd = 1'b1;
            default: txd = 1'b1;
        endcase
        shift_empty = (state_q == S_IDLE);
        run         = (state_q != S_IDLE);
    end

endmodule

// File: rtl/ser_tx9.sv
module ser_tx9
    import ser_tx9_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FAST_TICKS = 16,
    parameter int SLOW_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             txd
);

    localparam int DATA_W = 8;

    logic              en_q, nine_q, d9_q, fast_q, clksel_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic              tick, load, shift_empty, run;
    logic              unused_bits;

    assign unused_bits = ^{ctl_wdata[7], ctl_wdata[F_SYNC], ctl_wdata[F_EMPTY]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            nine_q   <= 1'b0;
            d9_q     <= 1'b0;
            fast_q   <= 1'b0;
            clksel_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q     <= ctl_wdata[F_EN];
            nine_q   <= ctl_wdata[F_NINE];
            d9_q     <= ctl_wdata[F_D9];
            fast_q   <= ctl_wdata[F_FAST];
            clksel_q <= ctl_wdata[F_CLK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= div_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (data_wr) begin
            hold_q      <= data_wdata;
            hold_full_q <= 1'b1;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end
    end

    assign ctl_rdata = {1'b0, clksel_q, 1'b0, shift_empty, fast_q, d9_q, nine_q, en_q};

    ser_tx9_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    ser_tx9_fsm #(
        .DATA_W     (DATA_W),
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .en          (en_q),
        .hold_full   (hold_full_q),
        .hold_data   (hold_q),
        .nine        (nine_q),
        .d9          (d9_q),
        .fast        (fast_q),
        .load        (load),
        .txd         (txd),
        .shift_empty (shift_empty),
        .run         (run)
    );

endmodule

// File: rtl/ser_tx9_chk.sv
module ser_tx9_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rdata,
    input logic       txd,
    input logic       hold_full
);

    // R1: line rests high whenever the shift register is empty
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[4] |-> txd);

    // R2: leaving empty puts the start bit on the line
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdata[4]) |-> !txd);

    // R5: a load only happens with a held byte
    a_r5_load_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdata[4]) |-> $past(hold_full));

    // R6: disabled transmitter keeps its byte
    a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !rdata[0]) |=> hold_full);

    // R7: disabled transmitter is empty on the next clock
    a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[0] |=> rdata[4]);

    // R10: pending byte loads one clock after a frame ends
    a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdata[4]) && hold_full && rdata[0]) |=> !rdata[4]);

endmodule

bind ser_tx9 ser_tx9_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdata     (ctl_rdata),
    .txd       (txd),
    .hold_full (hold_full_q)
);

// File: tb/ser_tx9_bench.sv
module ser_tx9_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic [7:0]       ctl_rdata;
    logic             data_wr = 1'b0;
    logic [7:0]       data_wdata = '0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             txd;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_tx9 u_ser_tx9 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_ctl(bit en, bit nine, bit d9, bit fast, bit cks, bit sync);
        return {1'b0, cks, sync, 1'b0, fast, d9, nine, en};
    endfunction

    function automatic int bit_period(int dv, bit fast);
        return (dv + 1) * (fast ? 16 : 64);
    endfunction

    function automatic logic [10:0] exp_frame(logic [7:0] d, bit nine, bit d9);
        return nine ? {1'b1, d9, d, 1'b0} : {1'b0, 1'b1, d, 1'b0};
    endfunction

    // each task is entered at a falling edge and returns at a falling edge
    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_wr = 1'b1; data_wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [DIV_W-1:0] v);
        div_wr = 1'b1; div_wdata = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    // t=0 is the first falling edge after the load edge
    task automatic grab(input int nb, input int tt,
                        input bit midc, input logic [7:0] mc,
                        input bit midd, input logic [7:0] md,
                        output logic [10:0] bits, output int lowcnt);
        bits = '0;
        lowcnt = 0;
        for (int t = 0; t < (nb + 2) * tt; t++) begin
            if (t % tt == tt / 2) bits[t / tt] = txd;
            if (!ctl_rdata[4]) lowcnt++;
            ctl_wr = 1'b0; data_wr = 1'b0;
            if (t == 5 && midc) begin ctl_wr = 1'b1; ctl_wdata = mc; end
            if (t == 5 && midd) begin data_wr = 1'b1; data_wdata = md; end
            @(negedge clk);
        end
        ctl_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] d, input bit nine, input bit d9,
                             input bit fast, input int dv, input bit midc,
                             input string tag);
        logic [10:0] bits;
        int          lowcnt;
        int          tt;
        int          nb;
        tt = bit_period(dv, fast);
        nb = nine ? 9 : 8;
        wr_div(DIV_W'(dv));
        wr_ctl(mk_ctl(1'b1, nine, d9, fast, 1'b0, 1'b0));
        wr_data(d);
        @(negedge clk);
        grab(nb, tt, midc, mk_ctl(1'b1, ~nine, ~d9, ~fast, 1'b0, 1'b0), 1'b0, 8'h00, bits, lowcnt);
        chk(bits == exp_frame(d, nine, d9), {tag, " R2/R3 frame bits"}, 32'(bits), 32'(exp_frame(d, nine, d9)));
        chk(lowcnt == (nb + 2) * tt, {tag, " R4/R5 busy cycles"}, lowcnt, (nb + 2) * tt);
        chk(ctl_rdata[4] && txd, {tag, " R5 empty after stop"}, {ctl_rdata[4], txd}, 2'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] bits;
        int          lowcnt;
        int          tt;
        bit          ok;
        void'($urandom(32'h0005_eed1));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1, "R1 txd in reset", txd, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd after reset", txd, 1'b1);
        chk(ctl_rdata == 8'h10, "R1 ctl_rdata after reset", ctl_rdata, 8'h10);

        // R9: fixed and stored fields
        wr_ctl(8'hE0);
        chk(ctl_rdata == 8'h50, "R9 readback 0xE0", ctl_rdata, 8'h50);
        wr_ctl(8'h3E);
        chk(ctl_rdata == 8'h1E, "R9 readback 0x3E", ctl_rdata, 8'h1E);

        // R2, R3, R4: directed frames
        run_frame(8'h00, 1'b0, 1'b0, 1'b1, 0, 1'b0, "dir0");
        run_frame(8'hFF, 1'b1, 1'b0, 1'b0, 1, 1'b0, "dir1");
        run_frame(8'hA5, 1'b1, 1'b1, 1'b1, 2, 1'b0, "dir2");
        // R9: clock-source bit set has no effect on frames
        wr_div(8'd0);
        wr_ctl(mk_ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
        chk(ctl_rdata == 8'h59, "R9 sync reads 0 clk stored", ctl_rdata, 8'h59);
        wr_data(8'h6B);
        @(negedge clk);
        grab(8, 16, 1'b0, 8'h00, 1'b0, 8'h00, bits, lowcnt);
        chk(bits == exp_frame(8'h6B, 1'b0, 1'b0), "R9 frame with clock-source set", 32'(bits), 32'(exp_frame(8'h6B, 1'b0, 1'b0)));

        // R8: control writes during a frame do not alter it
        run_frame(8'h3C, 1'b1, 1'b1, 1'b1, 0, 1'b1, "R8a");
        run_frame(8'hC3, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R8b");

        // random frames
        for (int i = 0; i < 12; i++) begin
            run_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom % 3), 1'b0, "rand");
        end

        // R10: byte queued during a frame follows one clock after it
        wr_div(8'd0);
        wr_ctl(mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        wr_data(8'h81);
        @(negedge clk);
        grab(9, 16, 1'b0, 8'h00, 1'b1, 8'h5A, bits, lowcnt);
        chk(bits == exp_frame(8'h81, 1'b1, 1'b1), "R10 first frame", 32'(bits), 32'(exp_frame(8'h81, 1'b1, 1'b1)));
        chk(ctl_rdata[4] && txd, "R10 one idle clock", {ctl_rdata[4], txd}, 2'b11);
        @(negedge clk);
        chk(!ctl_rdata[4] && !txd, "R10 second frame starts", {ctl_rdata[4], txd}, 2'b00);
        grab(9, 16, 1'b0, 8'h00, 1'b0, 8'h00, bits, lowcnt);
        chk(bits == exp_frame(8'h5A, 1'b1, 1'b1), "R10 second frame", 32'(bits), 32'(exp_frame(8'h5A, 1'b1, 1'b1)));
        chk(lowcnt == 11 * 16, "R10 second busy", lowcnt, 11 * 16);

        // R6: disabled transmitter holds the byte
        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        wr_data(8'h96);
        ok = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (!(txd && ctl_rdata[4])) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R6 nothing sent while disabled", ok, 1'b1);
        wr_ctl(mk_ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        grab(8, 16, 1'b0, 8'h00, 1'b0, 8'h00, bits, lowcnt);
        chk(bits == exp_frame(8'h96, 1'b0, 1'b0), "R6 held byte sent on enable", 32'(bits), 32'(exp_frame(8'h96, 1'b0, 1'b0)));

        // R7: disable during a frame
        wr_data(8'h00);
        @(negedge clk);
        tt = 0;
        repeat (20) begin
            if (!ctl_rdata[4]) tt++;
            @(negedge clk);
        end
        chk(tt == 20, "R7 frame running before disable", tt, 20);
        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        chk(ctl_rdata[4] && txd, "R7 stopped one clock after disable", {ctl_rdata[4], txd}, 2'b11);
        ok = 1'b1;
        repeat (100) begin
            if (!(txd && ctl_rdata[4])) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R7 line stays idle", ok, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule